// File: doc/BRIEF.md
# Snooping MESI Cache Line Controller

This block is the coherence controller that sits beside one processor's cache. Each line of the cache holds a single data word and one of four coherence states: Modified, Exclusive, Shared or Invalid. There is no tag. The processor's line index selects the line directly, and replacement is handled elsewhere. Two independent state machines share the line array. The processor-side engine serves loads and stores and, on a miss, asks the memory controller for data or for permission to store. The snoop-side engine answers read and invalidate queries that the memory controller sends on behalf of other caches.

Both engines reach the state and data arrays only while they hold an internal lock, which works as a test-and-set register. An engine keeps the lock from its first array read to its last array write. A processor miss that is waiting on the bus therefore cannot have its line altered under it. Because snoop service has its own engine, a stalled processor request cannot stop a snoop from being accepted. A shared bus-busy input tells the controller that some other cache has a transaction outstanding. While that input is high, the controller holds its own request back.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, and no response or memory request is pending. The first load to any line goes to memory.
- R2: A load that finds the line Invalid issues one memory request of kind 0 (read). It returns the word supplied by memory. The line becomes Exclusive when `mem_resp_excl` is 1 and Shared otherwise.
- R3: A load that finds the line Shared, Exclusive or Modified returns the stored word and issues no memory request.
- R4: A store that finds the line Exclusive writes the word and moves the line to Modified without any memory request.
- R5: A store that finds the line Shared issues kind 2 (upgrade). A store that finds the line Invalid issues kind 1 (read for ownership). The line becomes Modified and takes the store word only when `mem_resp_valid` arrives, and the processor response comes after it.
- R6: A store that finds the line Modified writes the word and issues no memory request.
- R7: No memory request is issued in a cycle that follows a cycle where `bus_busy` was high. A pending miss waits while `bus_busy` stays high and goes out once it falls.
- R8: A snoop with `snp_req_inv`=1 moves the line to Invalid. If the line was Modified, the snoop response carries `snp_resp_dirty`=1 and the line's word.
- R9: A snoop with `snp_req_inv`=0 moves Modified or Exclusive to Shared, leaves Shared and Invalid unchanged, and sets `snp_resp_dirty`=1 with the word only when the line was Modified.
- R10: The arrays are written only while one engine holds the lock. When both engines ask for the lock in the same cycle, the snoop engine wins. A load racing an invalidate to the same line therefore sees the snoop response first, and the load then misses.
- R11: The snoop engine holds the lock for fewer than 4 consecutive cycles, so a snoop is answered within 6 cycles of acceptance when the lock is free.
- R12: A processor request blocks. `cpu_req_ready` stays low from acceptance until `cpu_resp_valid`, and a missing load's response never comes before the memory response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_line | input | AW | Line index |
| cpu_req_wdata | input | DW | Store word |
| cpu_req_ready | output | 1 | Processor engine idle, request accepted |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DW | Load word (store word echoed for stores) |
| bus_busy | input | 1 | Another cache has a transaction outstanding |
| mem_req_valid | output | 1 | One-cycle request to the memory controller |
| mem_req_kind | output | 2 | 0 read, 1 read for ownership, 2 upgrade |
| mem_req_line | output | AW | Line index of the request |
| mem_resp_valid | input | 1 | Memory controller completion pulse |
| mem_resp_data | input | DW | Word returned for reads |
| mem_resp_excl | input | 1 | No other sharer: a read fill may be Exclusive |
| snp_req_valid | input | 1 | Snoop query present |
| snp_req_inv | input | 1 | 1 = invalidate, 0 = read |
| snp_req_line | input | AW | Snooped line index |
| snp_req_ready | output | 1 | Snoop engine idle, query accepted |
| snp_resp_valid | output | 1 | One-cycle snoop answer |
| snp_resp_dirty | output | 1 | Line was Modified, data supplied |
| snp_resp_data | output | DW | Supplied word |

## Verification
Each line is driven through a different path. One line walks a full cycle: a fill, then a silent store, then a snoop read that must return dirty data, then an upgrade. The returned data tells Exclusive apart from Modified, and the kind of the next store's request tells Shared apart from Modified. The Shared and Invalid store cases show whether the controller picks upgrade or read for ownership. A run with bus-busy held high separates a held request from a lost one. In the race test, a load and an invalidate arrive together on a Modified line, and the order of the two responses shows which engine won the lock.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_state_t;
  typedef enum logic [1:0] {OWN_NONE = 2'd0, OWN_CPU = 2'd1, OWN_SNP = 2'd2} lock_owner_t;
  localparam logic [1:0] MK_READ = 2'd0;
  localparam logic [1:0] MK_OWN  = 2'd1;
  localparam logic [1:0] MK_UPGR = 2'd2;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store #(
  parameter int LINES = 4,
  parameter int DW = 16,
  localparam int AW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            addr,
  input  logic                     st_we,
  input  mesi_pkg::line_state_t    st_wval,
  output mesi_pkg::line_state_t    st_rval,
  input  logic                     d_we,
  input  logic [DW-1:0]            d_wdata,
  output logic [DW-1:0]            d_rdata
);
  import mesi_pkg::*;
  line_state_t st_q [LINES];
  logic [DW-1:0] word_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else if (st_we) begin
      st_q[addr] <= st_wval;
    end
  end
  assign st_rval = st_q[addr];

  // single-port word array with registered read
  always_ff @(posedge clk) begin
    if (d_we) word_q[addr] <= d_wdata;
    d_rdata <= word_q[addr];
  end
endmodule

// File: rtl/mesi_lock.sv
module mesi_lock #(
  parameter int SNP_HOLD_MAX = 4,
  localparam int CW = $clog2(SNP_HOLD_MAX + 1) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_cpu,
  input  logic req_snp,
  input  logic rel_cpu,
  input  logic rel_snp,
  output logic gnt_cpu,
  output logic gnt_snp
);
  import mesi_pkg::*;
  lock_owner_t owner_q;
  logic [CW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= OWN_NONE;
    end else begin
      case (owner_q)
        OWN_NONE: if (req_snp) owner_q <= OWN_SNP;
                  else if (req_cpu) owner_q <= OWN_CPU;
        OWN_CPU:  if (rel_cpu) owner_q <= OWN_NONE;
        OWN_SNP:  if (rel_snp) owner_q <= OWN_NONE;
        default:  owner_q <= OWN_NONE;
      endcase
    end
  end
  assign gnt_cpu = (owner_q == OWN_CPU);
  assign gnt_snp = (owner_q == OWN_SNP);

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else if (gnt_snp) hold_q <= hold_q + 1'b1;
    else hold_q <= '0;
  end

  assert_snoop_priority_R10: assert property (@(posedge clk) disable iff (rst)
    (!gnt_cpu && !gnt_snp && req_cpu && req_snp) |=> gnt_snp);
  assert_snoop_hold_bounded_R11: assert property (@(posedge clk) disable iff (rst)
    gnt_snp |-> (hold_q < CW'(SNP_HOLD_MAX)));
endmodule

// File: rtl/mesi_cpu_engine.sv
module mesi_cpu_engine #(
  parameter int LINES = 4,
  parameter int DW = 16,
  localparam int AW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_line,
  input  logic [DW-1:0]         req_wdata,
  output logic                  req_ready,
  output logic                  resp_valid,
  output logic [DW-1:0]         resp_rdata,
  output logic                  lock_req,
  input  logic                  lock_gnt,
  output logic                  lock_rel,
  output logic [AW-1:0]         arr_addr,
  input  mesi_pkg::line_state_t st_rval,
  output logic                  st_we,
  output mesi_pkg::line_state_t st_wval,
  output logic                  d_we,
  output logic [DW-1:0]         d_wdata,
  input  logic [DW-1:0]         d_rdata,
  input  logic                  bus_busy,
  output logic                  mreq_valid,
  output logic [1:0]            mreq_kind,
  input  logic                  mresp_valid,
  input  logic [DW-1:0]         mresp_data,
  input  logic                  mresp_excl
);
  import mesi_pkg::*;
  typedef enum logic [2:0] {C_IDLE, C_LOCK, C_RD, C_EVAL, C_MREQ, C_MWAIT} cstate_t;
  cstate_t st_q;
  logic wr_q;
  logic [AW-1:0] line_q;
  logic [DW-1:0] wdata_q;
  logic hit;

  assign req_ready = (st_q == C_IDLE);
  assign lock_req  = (st_q == C_LOCK);
  assign arr_addr  = line_q;
  assign hit = wr_q ? (st_rval == ST_M || st_rval == ST_E) : (st_rval != ST_I);

  always_comb begin
    st_we = 1'b0; st_wval = ST_M; d_we = 1'b0; d_wdata = wdata_q; lock_rel = 1'b0;
    if (st_q == C_EVAL && hit) begin
      lock_rel = 1'b1;
      if (wr_q) begin
        d_we  = 1'b1;
        st_we = (st_rval == ST_E);
      end
    end else if (st_q == C_MWAIT && mresp_valid) begin
      lock_rel = 1'b1;
      d_we  = 1'b1;
      st_we = 1'b1;
      if (!wr_q) begin
        d_wdata = mresp_data;
        st_wval = mresp_excl ? ST_E : ST_S;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= C_IDLE; resp_valid <= 1'b0; mreq_valid <= 1'b0;
      wr_q <= 1'b0; line_q <= '0; wdata_q <= '0; resp_rdata <= '0; mreq_kind <= MK_READ;
    end else begin
      resp_valid <= 1'b0;
      mreq_valid <= 1'b0;
      case (st_q)
        C_IDLE: if (req_valid) begin
          wr_q <= req_write; line_q <= req_line; wdata_q <= req_wdata; st_q <= C_LOCK;
        end
        C_LOCK: if (lock_gnt) st_q <= C_RD;
        C_RD:   st_q <= C_EVAL;
        C_EVAL: if (hit) begin
          resp_valid <= 1'b1;
          resp_rdata <= wr_q ? wdata_q : d_rdata;
          st_q <= C_IDLE;
        end else begin
          mreq_kind <= !wr_q ? MK_READ : ((st_rval == ST_S) ? MK_UPGR : MK_OWN);
          st_q <= C_MREQ;
        end
        C_MREQ: if (!bus_busy) begin
          mreq_valid <= 1'b1; st_q <= C_MWAIT;
        end
        C_MWAIT: if (mresp_valid) begin
          resp_valid <= 1'b1;
          resp_rdata <= wr_q ? wdata_q : mresp_data;
          st_q <= C_IDLE;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assert_no_req_when_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mreq_valid |-> !$past(bus_busy));
  assert_load_blocks_R12: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(!req_ready));
endmodule

// File: rtl/mesi_snoop_engine.sv
module mesi_snoop_engine #(
  parameter int LINES = 4,
  parameter int DW = 16,
  localparam int AW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_inv,
  input  logic [AW-1:0]         req_line,
  output logic                  req_ready,
  output logic                  resp_valid,
  output logic                  resp_dirty,
  output logic [DW-1:0]         resp_data,
  output logic                  lock_req,
  input  logic                  lock_gnt,
  output logic                  lock_rel,
  output logic [AW-1:0]         arr_addr,
  input  mesi_pkg::line_state_t st_rval,
  output logic                  st_we,
  output mesi_pkg::line_state_t st_wval,
  input  logic [DW-1:0]         d_rdata
);
  import mesi_pkg::*;
  typedef enum logic [1:0] {S_IDLE, S_LOCK, S_RD, S_EVAL} sstate_t;
  sstate_t st_q;
  logic inv_q;
  logic [AW-1:0] line_q;

  assign req_ready = (st_q == S_IDLE);
  assign lock_req  = (st_q == S_LOCK);
  assign lock_rel  = (st_q == S_EVAL);
  assign arr_addr  = line_q;
  assign st_wval   = inv_q ? ST_I : ST_S;
  assign st_we     = (st_q == S_EVAL) &&
                     (inv_q ? (st_rval != ST_I) : (st_rval == ST_M || st_rval == ST_E));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; inv_q <= 1'b0; line_q <= '0;
      resp_valid <= 1'b0; resp_dirty <= 1'b0; resp_data <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          inv_q <= req_inv; line_q <= req_line; st_q <= S_LOCK;
        end
        S_LOCK: if (lock_gnt) st_q <= S_RD;
        S_RD:   st_q <= S_EVAL;
        S_EVAL: begin
          resp_valid <= 1'b1;
          resp_dirty <= (st_rval == ST_M);
          resp_data  <= d_rdata;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_snoop_answers_R9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(lock_gnt));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int LINES = 4,
  parameter int DW = 16,
  parameter int SNP_HOLD_MAX = 4,
  localparam int AW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req_valid,
  input  logic          cpu_req_write,
  input  logic [AW-1:0] cpu_req_line,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_req_ready,
  output logic          cpu_resp_valid,
  output logic [DW-1:0] cpu_resp_rdata,
  input  logic          bus_busy,
  output logic          mem_req_valid,
  output logic [1:0]    mem_req_kind,
  output logic [AW-1:0] mem_req_line,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data,
  input  logic          mem_resp_excl,
  input  logic          snp_req_valid,
  input  logic          snp_req_inv,
  input  logic [AW-1:0] snp_req_line,
  output logic          snp_req_ready,
  output logic          snp_resp_valid,
  output logic          snp_resp_dirty,
  output logic [DW-1:0] snp_resp_data
);
  import mesi_pkg::*;
  logic gnt_cpu, gnt_snp, lreq_cpu, lreq_snp, lrel_cpu, lrel_snp;
  logic [AW-1:0] addr_cpu, addr_snp, arr_addr;
  logic we_cpu, we_snp, st_we, d_we;
  line_state_t wv_cpu, wv_snp, st_wval, st_rval;
  logic dwe_cpu;
  logic [DW-1:0] dwd_cpu, d_rdata;

  mesi_lock #(.SNP_HOLD_MAX(SNP_HOLD_MAX)) u_lock (
    .clk(clk), .rst(rst), .req_cpu(lreq_cpu), .req_snp(lreq_snp),
    .rel_cpu(lrel_cpu), .rel_snp(lrel_snp), .gnt_cpu(gnt_cpu), .gnt_snp(gnt_snp));

  mesi_cpu_engine #(.LINES(LINES), .DW(DW)) u_cpu (
    .clk(clk), .rst(rst), .req_valid(cpu_req_valid), .req_write(cpu_req_write),
    .req_line(cpu_req_line), .req_wdata(cpu_req_wdata), .req_ready(cpu_req_ready),
    .resp_valid(cpu_resp_valid), .resp_rdata(cpu_resp_rdata),
    .lock_req(lreq_cpu), .lock_gnt(gnt_cpu), .lock_rel(lrel_cpu),
    .arr_addr(addr_cpu), .st_rval(st_rval), .st_we(we_cpu), .st_wval(wv_cpu),
    .d_we(dwe_cpu), .d_wdata(dwd_cpu), .d_rdata(d_rdata), .bus_busy(bus_busy),
    .mreq_valid(mem_req_valid), .mreq_kind(mem_req_kind),
    .mresp_valid(mem_resp_valid), .mresp_data(mem_resp_data), .mresp_excl(mem_resp_excl));
  assign mem_req_line = addr_cpu;

  mesi_snoop_engine #(.LINES(LINES), .DW(DW)) u_snp (
    .clk(clk), .rst(rst), .req_valid(snp_req_valid), .req_inv(snp_req_inv),
    .req_line(snp_req_line), .req_ready(snp_req_ready), .resp_valid(snp_resp_valid),
    .resp_dirty(snp_resp_dirty), .resp_data(snp_resp_data),
    .lock_req(lreq_snp), .lock_gnt(gnt_snp), .lock_rel(lrel_snp),
    .arr_addr(addr_snp), .st_rval(st_rval), .st_we(we_snp), .st_wval(wv_snp),
    .d_rdata(d_rdata));

  // array port follows the lock holder
  assign arr_addr = gnt_snp ? addr_snp : addr_cpu;
  assign st_we    = gnt_snp ? we_snp : (gnt_cpu & we_cpu);
  assign st_wval  = gnt_snp ? wv_snp : wv_cpu;
  assign d_we     = gnt_cpu & dwe_cpu;

  mesi_line_store #(.LINES(LINES), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .addr(arr_addr), .st_we(st_we), .st_wval(st_wval),
    .st_rval(st_rval), .d_we(d_we), .d_wdata(dwd_cpu), .d_rdata(d_rdata));

  assert_write_under_lock_R10: assert property (@(posedge clk) disable iff (rst)
    (we_cpu || dwe_cpu || we_snp) |-> (gnt_cpu || gnt_snp));
  assert_modified_needs_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (st_we && st_wval == ST_M && (st_rval == ST_S || st_rval == ST_I)) |-> mem_resp_valid);
endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;
  localparam int LINES = 4;
  localparam int DW = 16;
  localparam int AW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req_valid = 0, cpu_req_write = 0; logic [AW-1:0] cpu_req_line = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_resp_valid; logic [DW-1:0] cpu_resp_rdata;
  logic bus_busy = 0, mem_req_valid; logic [1:0] mem_req_kind; logic [AW-1:0] mem_req_line;
  logic mem_resp_valid = 0, mem_resp_excl = 0; logic [DW-1:0] mem_resp_data = '0;
  logic snp_req_valid = 0, snp_req_inv = 0; logic [AW-1:0] snp_req_line = '0;
  logic snp_req_ready, snp_resp_valid, snp_resp_dirty; logic [DW-1:0] snp_resp_data;

  mesi_line_ctrl #(.LINES(LINES), .DW(DW)) i_mesi_line_ctrl (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc_total = 0;
  logic [DW-1:0] mem_word = '0; logic mem_ex = 0;
  int got_cpu, got_snp, nreq, cpu_cyc, snp_cyc, mresp_cyc, ready_bad;
  logic [1:0] rkind; logic [DW-1:0] cdata, sdata; logic sdirty;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 20000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic start(input bit cv, input bit w, input int cl, input logic [DW-1:0] d,
                       input bit sv, input bit inv, input int sl);
    @(negedge clk);
    cpu_req_valid = cv; cpu_req_write = w; cpu_req_line = AW'(cl); cpu_req_wdata = d;
    snp_req_valid = sv; snp_req_inv = inv; snp_req_line = AW'(sl);
    @(negedge clk);
    cpu_req_valid = 0; snp_req_valid = 0;
  endtask

  task automatic run(input bit wc, input bit ws, input int maxc);
    int cd = 0;
    got_cpu = 0; got_snp = 0; nreq = 0; ready_bad = 0;
    cpu_cyc = 0; snp_cyc = 0; mresp_cyc = 0;
    for (int c = 1; c <= maxc; c++) begin
      if (c > 1) @(negedge clk);
      if (mem_req_valid) begin nreq++; rkind = mem_req_kind; cd = 3; end
      if (cpu_resp_valid) begin got_cpu = 1; cdata = cpu_resp_rdata; cpu_cyc = c; end
      else if (wc && !got_cpu && cpu_req_ready) ready_bad++;
      if (snp_resp_valid) begin
        got_snp = 1; sdata = snp_resp_data; sdirty = snp_resp_dirty; snp_cyc = c;
      end
      if (cd == 1) begin
        mem_resp_valid = 1; mem_resp_data = mem_word; mem_resp_excl = mem_ex;
        mresp_cyc = c; cd = 0;
      end else begin
        mem_resp_valid = 0;
        if (cd > 1) cd--;
      end
      if ((wc || ws) && (!wc || got_cpu) && (!ws || got_snp) && cd == 0 && !mem_resp_valid)
        break;
    end
    mem_resp_valid = 0;
  endtask

  task automatic t_reset();
    chk(cpu_req_ready === 1'b1, "R1 ready after reset", cpu_req_ready, 1);
    chk(mem_req_valid === 1'b0 && cpu_resp_valid === 1'b0, "R1 idle outputs",
        {mem_req_valid, cpu_resp_valid}, 0);
    chk(snp_req_ready === 1'b1, "R1 snoop ready", snp_req_ready, 1);
  endtask

  task automatic t_line0_walk();
    mem_word = 16'hA1A1; mem_ex = 1;
    start(1, 0, 0, '0, 0, 0, 0); run(1, 0, 40);
    chk(nreq == 1, "R1 first load goes to memory", nreq, 1);
    chk(rkind == 2'd0, "R2 miss kind read", rkind, 0);
    chk(got_cpu == 1 && cdata == 16'hA1A1, "R2 fill data", cdata, 16'hA1A1);
    chk(ready_bad == 0 && cpu_cyc > mresp_cyc, "R12 load blocks", cpu_cyc, mresp_cyc + 1);
    start(1, 0, 0, '0, 0, 0, 0); run(1, 0, 40);
    chk(nreq == 0 && cdata == 16'hA1A1, "R3 hit in E", cdata, 16'hA1A1);
    start(1, 1, 0, 16'hB2B2, 0, 0, 0); run(1, 0, 40);
    chk(got_cpu == 1 && nreq == 0, "R4 silent E store", nreq, 0);
    start(0, 0, 0, '0, 1, 0, 0); run(0, 1, 40);
    chk(sdirty == 1 && sdata == 16'hB2B2, "R4 line became M (R9 dirty read)", sdata, 16'hB2B2);
    chk(got_snp == 1 && snp_cyc <= 6, "R11 snoop latency", snp_cyc, 6);
    start(1, 1, 0, 16'hC3C3, 0, 0, 0); run(1, 0, 40);
    chk(nreq == 1 && rkind == 2'd2, "R9 M->S then upgrade", rkind, 2);
    start(1, 0, 0, '0, 0, 0, 0); run(1, 0, 40);
    chk(nreq == 0 && cdata == 16'hC3C3, "R3 hit in M", cdata, 16'hC3C3);
    start(1, 1, 0, 16'hD4D4, 0, 0, 0); run(1, 0, 40);
    chk(got_cpu == 1 && nreq == 0, "R6 M store silent", nreq, 0);
    start(0, 0, 0, '0, 1, 1, 0); run(0, 1, 40);
    chk(sdirty == 1 && sdata == 16'hD4D4, "R8 inval of M supplies data", sdata, 16'hD4D4);
    mem_word = 16'h5E5E; mem_ex = 0;
    start(1, 0, 0, '0, 0, 0, 0); run(1, 0, 40);
    chk(nreq == 1 && rkind == 2'd0 && cdata == 16'h5E5E, "R8 line invalid after snoop", cdata, 16'h5E5E);
    start(0, 0, 0, '0, 1, 0, 0); run(0, 1, 40);
    chk(got_snp == 1 && sdirty == 0, "R9 read of S no data", sdirty, 0);
    start(1, 1, 0, 16'h0F0F, 0, 0, 0); run(1, 0, 40);
    chk(nreq == 1 && rkind == 2'd2, "R2 shared fill / R9 S stays S", rkind, 2);
  endtask

  task automatic t_store_paths();
    mem_word = 16'h9999; mem_ex = 0;
    start(1, 0, 1, '0, 0, 0, 0); run(1, 0, 40);
    start(1, 1, 1, 16'h1111, 0, 0, 0); run(1, 0, 40);
    chk(nreq == 1 && rkind == 2'd2, "R5 S store upgrade", rkind, 2);
    chk(cpu_cyc > mresp_cyc, "R5 store waits for grant", cpu_cyc, mresp_cyc + 1);
    start(0, 0, 1, '0, 1, 0, 1); run(0, 1, 40);
    chk(sdirty == 1 && sdata == 16'h1111, "R5 upgraded line is M", sdata, 16'h1111);
    start(1, 1, 2, 16'h2222, 0, 0, 0); run(1, 0, 40);
    chk(nreq == 1 && rkind == 2'd1, "R5 I store read-for-ownership", rkind, 1);
    start(1, 0, 2, '0, 0, 0, 0); run(1, 0, 40);
    chk(nreq == 0 && cdata == 16'h2222, "R5 store word kept", cdata, 16'h2222);
  endtask

  task automatic t_exclusive_snoop();
    mem_word = 16'h3333; mem_ex = 1;
    start(1, 0, 3, '0, 0, 0, 0); run(1, 0, 40);
    start(0, 0, 3, '0, 1, 0, 3); run(0, 1, 40);
    chk(got_snp == 1 && sdirty == 0, "R9 read of E no data", sdirty, 0);
    start(1, 1, 3, 16'h3434, 0, 0, 0); run(1, 0, 40);
    chk(nreq == 1 && rkind == 2'd2, "R9 E became S", rkind, 2);
    start(0, 0, 3, '0, 1, 1, 3); run(0, 1, 40);
    start(0, 0, 3, '0, 1, 0, 3); run(0, 1, 40);
    chk(got_snp == 1 && sdirty == 0, "R9 read of I no data", sdirty, 0);
  endtask

  task automatic t_bus_busy();
    mem_word = 16'h4444; mem_ex = 0;
    bus_busy = 1;
    start(1, 0, 3, '0, 0, 0, 0); run(0, 0, 12);
    chk(nreq == 0 && got_cpu == 0, "R7 held while busy", nreq, 0);
    bus_busy = 0;
    run(1, 0, 40);
    chk(nreq == 1 && cdata == 16'h4444, "R7 issued after busy falls", cdata, 16'h4444);
  endtask

  task automatic t_race();
    mem_word = 16'h7777; mem_ex = 0;
    start(1, 0, 2, '0, 1, 1, 2); run(1, 1, 60);
    chk(got_snp == 1 && got_cpu == 1 && snp_cyc < cpu_cyc, "R10 snoop wins lock", snp_cyc, cpu_cyc);
    chk(sdirty == 1 && sdata == 16'h2222, "R10 snoop saw M line", sdata, 16'h2222);
    chk(nreq == 1 && rkind == 2'd0 && cdata == 16'h7777, "R10 load then misses", cdata, 16'h7777);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_line0_walk();
    t_store_paths();
    t_exclusive_snoop();
    t_bus_busy();
    t_race();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule